// File: doc/BRIEF.md
# Discrete PID Voltage Controller

This block is the digital compensator in a voltage-mode buck regulation loop. Once per switching period a single-cycle trigger from the pulse-width modulator starts an update. The block takes the quantized output voltage, which arrives from a flash converter as a thermometer word, converts it to a binary level and subtracts that level from a reference code to form a signed error.

The update then builds three terms from three signed fixed-point gains, each 16 bits wide. The proportional term scales the present error. The integral term scales a running sum of errors, which removes steady-state offset. The derivative term scales the change in error since the previous update. The weighted sum is shifted right by a fixed number of fraction bits and clamped into the duty range. It is then presented as a 6-bit duty word, together with a one-cycle valid strobe, to the counter-compare modulator. The integrator is frozen while the output is clamped, so a long saturation does not wind it up.

Top module: `pidc_top`

## Requirements
- R1: While reset is low, the duty word is 0 and the valid strobe is low. Reset also clears the integrator and the stored previous error, so the first derivative term after reset equals the error itself.
- R2: The feedback input is a 7-bit thermometer word. Its binary level is the number of bits set in it, whatever their positions, so a bubble is tolerated.
- R3: The error is the signed difference reference code minus binary level. The proportional contribution is the proportional gain times the error.
- R4: The gains are signed two's-complement numbers with FRAC (default 8) fraction bits. The summed result is shifted arithmetically right by FRAC bits, which rounds toward minus infinity, before it is clamped.
- R5: On every update the integrator adds the new error, and the integral contribution uses the updated sum.
- R6: The derivative contribution is the derivative gain times the current error minus the error of the previous update.
- R7: The duty word is the shifted sum clamped to the range 0 to 63: a negative sum gives 0 and a sum above 63 gives 63.
- R8: When the shifted sum falls outside 0 to 63, the integrator keeps its previous value (anti-windup).
- R9: The integrator saturates at the limits of its signed ACC_W-bit range instead of wrapping.
- R10: The new duty word and a valid strobe one clock wide appear two clock edges after the edge that samples the trigger. Without a trigger the duty word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | One-cycle start of an update, once per switching period |
| adc_therm | input | 7 | Thermometer-coded output-voltage level |
| ref_code | input | 3 | Binary reference level |
| kp | input | 16 | Proportional gain, signed fixed point |
| ki | input | 16 | Integral gain, signed fixed point |
| kd | input | 16 | Derivative gain, signed fixed point |
| duty | output | 6 | Duty word for the modulator |
| duty_vld | output | 1 | One-cycle strobe marking a new duty word |

## Verification
The bench builds the block with a 3-bit converter, 16-bit gains, 8 fraction bits and a 6-bit duty word, which matches the default configuration. It shrinks the integrator to 8 bits, so its saturation limit of 127 is reached within twenty updates of maximum error, and the bench can show the difference from a wrapping accumulator by reading the held sum back through a quarter-scale integral gain. With the 8 fraction bits, a gain of 256 acts as unity, so each term can be isolated and its expected value computed by hand. The same setting lets the bench reach both clamp limits and the anti-windup hold with error codes of a few steps.

// File: rtl/pidc_pkg.sv
package pidc_pkg;
   localparam int PIDC_ADC_BITS = 3;
   localparam int PIDC_COEF_W   = 16;
   localparam int PIDC_FRAC     = 8;
   localparam int PIDC_ACC_W    = 12;
   localparam int PIDC_DUTY_W   = 6;
endpackage

// File: rtl/pidc_thermo.sv
module pidc_thermo #(
   parameter int ADC_BITS = pidc_pkg::PIDC_ADC_BITS,
   localparam int LEVELS  = (1 << ADC_BITS) - 1
) (
   input  logic [LEVELS-1:0]   therm,
   output logic [ADC_BITS-1:0] level
);
   if (ADC_BITS < 2) begin : g_bad_bits
      $error("pidc_thermo: ADC_BITS must be at least 2");
   end

   // R2: running population count, bubble tolerant
   logic [ADC_BITS-1:0] part [0:LEVELS];
   assign part[0] = '0;
   for (genvar gi = 0; gi < LEVELS; gi++) begin : g_cnt
      assign part[gi+1] = part[gi] + {{(ADC_BITS-1){1'b0}}, therm[gi]};
   end
   assign level = part[LEVELS];
endmodule

// File: rtl/pidc_err.sv
module pidc_err #(
   parameter int ADC_BITS = pidc_pkg::PIDC_ADC_BITS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       trig,
   input  logic [ADC_BITS-1:0]        level,
   input  logic [ADC_BITS-1:0]        ref_code,
   output logic signed [ADC_BITS:0]   err_q,
   output logic signed [ADC_BITS+1:0] dif_q,
   output logic                       s1_vld
);
   logic signed [ADC_BITS:0] err_new;
   assign err_new = $signed({1'b0, ref_code}) - $signed({1'b0, level});

   // err_q doubles as the previous-update error when the next trigger comes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= '0;
         dif_q  <= '0;
         s1_vld <= 1'b0;
      end else begin
         s1_vld <= trig;
         if (trig) begin
            err_q <= err_new;
            dif_q <= (ADC_BITS+2)'(err_new) - (ADC_BITS+2)'(err_q);
         end
      end
   end

   // R6: stored error only moves on an update
   p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(err_q) |-> $past(trig));
endmodule

// File: rtl/pidc_core.sv
module pidc_core #(
   parameter int ADC_BITS = pidc_pkg::PIDC_ADC_BITS,
   parameter int COEF_W   = pidc_pkg::PIDC_COEF_W,
   parameter int FRAC     = pidc_pkg::PIDC_FRAC,
   parameter int ACC_W    = pidc_pkg::PIDC_ACC_W,
   parameter int DUTY_W   = pidc_pkg::PIDC_DUTY_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       s1_vld,
   input  logic signed [ADC_BITS:0]   err,
   input  logic signed [ADC_BITS+1:0] dif,
   input  logic [COEF_W-1:0]          kp,
   input  logic [COEF_W-1:0]          ki,
   input  logic [COEF_W-1:0]          kd,
   output logic [DUTY_W-1:0]          duty,
   output logic                       duty_vld
);
   localparam int SUM_W = COEF_W + ACC_W + 4;
   localparam logic signed [ACC_W:0] IMAX = {2'b00, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W:0] IMIN = {2'b11, {(ACC_W-1){1'b0}}};
   localparam logic signed [SUM_W-1:0] DTOP = SUM_W'((2 ** DUTY_W) - 1);

   if (FRAC >= COEF_W) begin : g_bad_frac
      $error("pidc_core: FRAC must be below COEF_W");
   end
   if (ACC_W <= ADC_BITS + 2) begin : g_bad_acc
      $error("pidc_core: ACC_W too narrow for the error");
   end

   logic signed [ACC_W-1:0] integ;
   logic signed [ACC_W:0]   i_sum;
   logic signed [ACC_W-1:0] integ_c;
   logic signed [SUM_W-1:0] acc, scaled;
   logic                    hi, lo, sat;
   logic [DUTY_W-1:0]       duty_n;

   always_comb begin
      // R5/R9: candidate integrator, saturated to its own range
      i_sum = (ACC_W+1)'(integ) + (ACC_W+1)'(err);
      if (i_sum > IMAX)      integ_c = IMAX[ACC_W-1:0];
      else if (i_sum < IMIN) integ_c = IMIN[ACC_W-1:0];
      else                   integ_c = i_sum[ACC_W-1:0];
      acc = SUM_W'($signed(kp)) * SUM_W'(err)
          + SUM_W'($signed(ki)) * SUM_W'(integ_c)
          + SUM_W'($signed(kd)) * SUM_W'(dif);
      scaled = acc >>> FRAC;
      lo  = scaled < 0;
      hi  = scaled > DTOP;
      sat = lo | hi;
      if (lo)      duty_n = '0;
      else if (hi) duty_n = '1;
      else         duty_n = scaled[DUTY_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         integ    <= '0;
         duty     <= '0;
         duty_vld <= 1'b0;
      end else begin
         duty_vld <= s1_vld;
         if (s1_vld) begin
            duty <= duty_n;
            if (!sat) integ <= integ_c;
         end
      end
   end

   // R8: integrator changes only on an unclamped update
   p_windup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(integ) |-> ($past(s1_vld) && !$past(sat)));
endmodule

// File: rtl/pidc_top.sv
module pidc_top #(
   parameter int ADC_BITS = pidc_pkg::PIDC_ADC_BITS,
   parameter int COEF_W   = pidc_pkg::PIDC_COEF_W,
   parameter int FRAC     = pidc_pkg::PIDC_FRAC,
   parameter int ACC_W    = pidc_pkg::PIDC_ACC_W,
   parameter int DUTY_W   = pidc_pkg::PIDC_DUTY_W,
   localparam int LEVELS  = (1 << ADC_BITS) - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig,
   input  logic [LEVELS-1:0]   adc_therm,
   input  logic [ADC_BITS-1:0] ref_code,
   input  logic [COEF_W-1:0]   kp,
   input  logic [COEF_W-1:0]   ki,
   input  logic [COEF_W-1:0]   kd,
   output logic [DUTY_W-1:0]   duty,
   output logic                duty_vld
);
   logic [ADC_BITS-1:0]        level;
   logic signed [ADC_BITS:0]   err_q;
   logic signed [ADC_BITS+1:0] dif_q;
   logic                       s1_vld;

   pidc_thermo #(.ADC_BITS(ADC_BITS)) u_thermo (
      .therm(adc_therm), .level(level));

   pidc_err #(.ADC_BITS(ADC_BITS)) u_err (
      .clk(clk), .rst_n(rst_n), .trig(trig), .level(level),
      .ref_code(ref_code), .err_q(err_q), .dif_q(dif_q), .s1_vld(s1_vld));

   pidc_core #(.ADC_BITS(ADC_BITS), .COEF_W(COEF_W), .FRAC(FRAC),
               .ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_core (
      .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .err(err_q), .dif(dif_q),
      .kp(kp), .ki(ki), .kd(kd), .duty(duty), .duty_vld(duty_vld));

   // R10: strobe follows a trigger by two edges
   p_strobe_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      duty_vld |-> $past(trig, 2));
   // R10: duty word moves only with the strobe
   p_duty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (duty != $past(duty)) |-> duty_vld);
endmodule

// File: tb/pidc_top_test.sv
module pidc_top_test;
   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig = 1'b0;
   logic [6:0]  adc_therm = '0;
   logic [2:0]  ref_code = '0;
   logic [15:0] kp = '0, ki = '0, kd = '0;
   logic [5:0]  duty;
   logic        duty_vld;
   int          total = 0;
   int          bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   pidc_top #(.ADC_BITS(3), .COEF_W(16), .FRAC(8), .ACC_W(8), .DUTY_W(6)) uut (
      .clk(clk), .rst_n(rst_n), .trig(trig), .adc_therm(adc_therm),
      .ref_code(ref_code), .kp(kp), .ki(ki), .kd(kd),
      .duty(duty), .duty_vld(duty_vld));

   function automatic logic [6:0] th(input int n);
      return 7'((1 << n) - 1);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; trig = 1'b0;
      kp = '0; ki = '0; kd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one update; returns duty sampled at the strobe
   task automatic upd(input int rc, input logic [6:0] t, output int d);
      @(negedge clk);
      ref_code = 3'(rc); adc_therm = t; trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      @(negedge clk);
      d = int'(duty);
   endtask

   task automatic t_reset();
      int d;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 duty in reset", int'(duty), 0);
      chk("R1 strobe in reset", int'(duty_vld), 0);
      rst_n = 1'b1;
      kd = 16'(256);
      upd(3, th(0), d);
      chk("R1 first derivative equals error", d, 3);
   endtask

   task automatic t_prop();
      int d;
      do_reset();
      kp = 16'(512);
      upd(5, th(2), d);  chk("R3 proportional 2*3", d, 6);
      kp = 16'(256);
      upd(5, 7'b0000101, d); chk("R2 bubble word counts 2", d, 3);
      upd(2, 7'b1000000, d); chk("R2 single high bit counts 1", d, 1);
   endtask

   task automatic t_clamp();
      int d;
      do_reset();
      kp = 16'(512);
      upd(1, th(5), d);  chk("R7 negative clamps to 0", d, 0);
      kp = 16'(4096);
      upd(7, th(0), d);  chk("R7 high clamps to 63", d, 63);
   endtask

   task automatic t_frac();
      int d;
      do_reset();
      kp = 16'(128);
      upd(5, th(0), d);  chk("R4 half gain floors 2.5", d, 2);
      kp = 16'(-128);
      upd(0, th(5), d);  chk("R4 negative gain negative error", d, 2);
   endtask

   task automatic t_deriv();
      int d;
      do_reset();
      kd = 16'(256);
      upd(3, th(0), d);  chk("R6 derivative first", d, 3);
      upd(3, th(0), d);  chk("R6 derivative steady", d, 0);
      upd(5, th(0), d);  chk("R6 derivative step", d, 2);
   endtask

   task automatic t_integ();
      int d;
      do_reset();
      ki = 16'(256);
      upd(4, th(2), d);  chk("R5 integral 1", d, 2);
      upd(4, th(2), d);  chk("R5 integral 2", d, 4);
      upd(4, th(2), d);  chk("R5 integral 3", d, 6);
   endtask

   task automatic t_windup();
      int d;
      do_reset();
      ki = 16'(256);
      for (int i = 1; i <= 14; i++) begin
         upd(7, th(0), d);
         if (i == 9)  chk("R5 integral reaches 63", d, 63);
         if (i == 12) chk("R7 clamped while saturated", d, 63);
      end
      upd(6, th(7), d);  chk("R8 held integrator releases", d, 62);
   endtask

   task automatic t_isat();
      int d;
      do_reset();
      for (int i = 0; i < 20; i++) upd(7, th(0), d);
      ki = 16'(64);
      upd(3, th(3), d);  chk("R9 integrator held at 127", d, 31);
   endtask

   task automatic t_timing();
      int d;
      do_reset();
      kp = 16'(256);
      @(negedge clk);
      ref_code = 3'd6; adc_therm = th(2); trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      chk("R10 no strobe after one edge", int'(duty_vld), 0);
      @(negedge clk);
      chk("R10 strobe after two edges", int'(duty_vld), 1);
      chk("R10 duty after two edges", int'(duty), 4);
      @(negedge clk);
      chk("R10 strobe one cycle", int'(duty_vld), 0);
      adc_therm = th(0);
      repeat (5) @(negedge clk);
      chk("R10 duty held without trigger", int'(duty), 4);
      upd(6, th(0), d);
      chk("R10 next trigger updates", d, 6);
   endtask

   initial begin
      #(CLK_PER * 100000);
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_prop();
      t_clamp();
      t_frac();
      t_deriv();
      t_integ();
      t_windup();
      t_isat();
      t_timing();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule